// File: doc/BRIEF.md
# Threshold Alert Comparator with Run Qualification

This block watches a stream of signed conversion results and raises an alert when results leave a programmed band. Each result arrives with a one-cycle valid strobe and is compared, in two's complement, against a low and a high threshold supplied by the surrounding register logic. An alert is raised only after a programmable number of back-to-back qualifying results (one, two or four), which filters single outliers.

Two detection styles are offered. In the one-sided style, only results above the high threshold qualify, and a non-latched alert drops only when a result goes below the low threshold, so the gap between the thresholds acts as hysteresis. In the band style, results on either side of the band qualify and a non-latched alert drops on the first in-band result. A latch option instead holds the alert until the host reads the result or services an SMBus alert response. The alert level follows a polarity option, and one encoding of the run-length field switches the comparator off and releases the pin to high impedance through an output-enable.

Top module: `thr_alert_cmp`

## Requirements
- R1: After reset the pin is released (`alert_oe` = 0), `alert_level` is 1 (inactive, active-low polarity) and no alert or run count is held.
- R2: With `cfg_queue` = 2'b11 the comparator is off: `alert_oe` is 0, `alert_level` shows the inactive level for the current polarity, the held alert and run count clear on the next edge, and results have no effect.
- R3: With `cfg_window` = 0 a result qualifies when it is greater than `thr_hi`; `cfg_queue` 2'b00, 2'b01 and 2'b10 need 1, 2 and 4 consecutive qualifying results, and the alert shows from the edge that accepts the last of them.
- R4: A valid result that does not qualify resets the run count to zero, so the run must start again.
- R5: With `cfg_window` = 0 and `cfg_latch` = 0, an asserted alert stays asserted for results from `thr_lo` to `thr_hi` inclusive and clears on a result below `thr_lo`.
- R6: With `cfg_window` = 1 a result qualifies when it is above `thr_hi` or below `thr_lo`; with `cfg_latch` = 0 the alert clears on a result from `thr_lo` to `thr_hi` inclusive.
- R7: With `cfg_latch` = 1 an asserted alert ignores in-band results and clears on the edge that samples `conv_read` or `alert_resp` high; a qualifying result accepted on that same edge keeps it asserted.
- R8: With `cfg_latch` = 0, `conv_read` and `alert_resp` have no effect.
- R9: `alert_level` equals the alert state when `cfg_active_high` = 1 and its inverse when 0, following the polarity input without a clock edge.
- R10: A change of `cfg_queue` or `cfg_window` clears the run count and the alert on the next edge; a result presented in the cycle of the change is discarded.
- R11: Comparisons are signed: with `thr_lo` = 12'h800 and `thr_hi` = 12'h7FF the one-sided style never qualifies, and 12'hFFF (-1) is not above a high threshold of 100.
- R12: With `res_valid` low, the run count and a non-latched alert hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe: `res_data` holds a new result |
| res_data | input | DATA_W | Signed conversion result |
| thr_lo | input | DATA_W | Signed low threshold |
| thr_hi | input | DATA_W | Signed high threshold |
| cfg_window | input | 1 | 0 one-sided style, 1 band style |
| cfg_active_high | input | 1 | 0 alert drives low, 1 alert drives high |
| cfg_latch | input | 1 | 1 holds the alert until acknowledged |
| cfg_queue | input | 2 | Run length 00=1, 01=2, 10=4; 11 disables |
| conv_read | input | 1 | Strobe: host read the result |
| alert_resp | input | 1 | Strobe: SMBus alert response serviced |
| alert_level | output | 1 | Alert pin value |
| alert_oe | output | 1 | Pin output-enable; 0 means high impedance |

## Verification
A run counter stuck or cleared at the wrong moment shows at the pin within one result: the alert arrives a result early or late, or never, on the first run whose length sits at the programmed limit. A held alert state that is wrong shows on the first following cycle, since the level is a direct function of it and the polarity; a missed clear on a configuration change or acknowledge shows as an alert still driven on the next cycle. The bench compares the pin against a bench model every cycle, so each such fault surfaces on the cycle after the edge that should have changed the state.

// File: rtl/thr_alert_pkg.sv
// Shared definitions for the threshold alert comparator.
// Assumes run lengths never exceed RUN_MAX.
package thr_alert_pkg;

    typedef enum logic [1:0] {
        Q_RUN1 = 2'b00,
        Q_RUN2 = 2'b01,
        Q_RUN4 = 2'b10,
        Q_OFF  = 2'b11
    } queue_e;

    localparam int RUN_MAX = 4;
    localparam int CNT_W   = $clog2(RUN_MAX + 1);

    // Number of consecutive qualifying results required for a queue code.
    function automatic logic [CNT_W-1:0] run_needed(input queue_e q);
        case (q)
            Q_RUN1:  run_needed = CNT_W'(1);
            Q_RUN2:  run_needed = CNT_W'(2);
            Q_RUN4:  run_needed = CNT_W'(4);
            default: run_needed = CNT_W'(RUN_MAX);
        endcase
    endfunction

endpackage

// File: rtl/thr_range_cmp.sv
// Signed range classifier. Decides whether a result counts toward an
// alert and whether it releases a non-latched alert.
// Assumes all operands are two's complement of the same width.
module thr_range_cmp #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  logic              window,
    output logic              hit,
    output logic              release_hit
);

    logic over_hi;
    logic under_lo;

    // Signed comparisons against both thresholds.
    always_comb begin
        over_hi  = $signed(data) > $signed(hi);
        under_lo = $signed(data) < $signed(lo);
    end

    // Style select: one-sided with hysteresis, or two-sided band.
    always_comb begin
        if (window) begin
            hit         = over_hi | under_lo;
            release_hit = ~(over_hi | under_lo);
        end else begin
            hit         = over_hi;
            release_hit = under_lo;
        end
    end

endmodule

// File: rtl/thr_run_cnt.sv
// Consecutive-hit counter. Counts accepted qualifying results,
// saturates at RUN_MAX, and restarts on any accepted non-qualifying one.
// Assumes flush has priority over step.
module thr_run_cnt
    import thr_alert_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             step,
    input  logic             hit,
    input  logic [CNT_W-1:0] need,
    output logic [CNT_W-1:0] cnt,
    output logic             reached
);

    logic [CNT_W-1:0] cnt_inc;

    // Saturating increment and run-length test.
    always_comb begin
        cnt_inc = (cnt == CNT_W'(RUN_MAX)) ? cnt : cnt + CNT_W'(1);
        reached = step & hit & (cnt_inc >= need);
    end

    // Run count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (flush) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= hit ? cnt_inc : '0;
        end
    end

endmodule

// File: rtl/thr_alert_state.sv
// Alert state flop with set, release and acknowledge.
// Priority: flush, then set, then clear (acknowledge or release).
module thr_alert_state (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic set,
    input  logic latch,
    input  logic rel,
    input  logic ack,
    output logic on
);

    // Hold, set or clear the alert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on <= 1'b0;
        end else if (flush) begin
            on <= 1'b0;
        end else if (set) begin
            on <= 1'b1;
        end else if (latch) begin
            if (ack) on <= 1'b0;
        end else if (rel) begin
            on <= 1'b0;
        end
    end

endmodule

// File: rtl/thr_alert_cmp.sv
// Threshold alert comparator top. Detects configuration changes,
// gates results, and drives the pin level and output-enable.
// Assumes res_valid, conv_read and alert_resp are one-cycle strobes
// synchronous to clk.
module thr_alert_cmp
    import thr_alert_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic              cfg_window,
    input  logic              cfg_active_high,
    input  logic              cfg_latch,
    input  logic [1:0]        cfg_queue,
    input  logic              conv_read,
    input  logic              alert_resp,
    output logic              alert_level,
    output logic              alert_oe
);

    queue_e           q_now;
    queue_e           q_prev;
    logic             w_prev;
    logic             cfg_chg;
    logic             enabled;
    logic             flush;
    logic             step;
    logic             hit;
    logic             release_hit;
    logic [CNT_W-1:0] run_cnt;
    logic             reached;
    logic             alert_on;
    logic             active;

    // Shadow copies of the fields whose change restarts detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_prev <= Q_OFF;
            w_prev <= 1'b0;
        end else begin
            q_prev <= q_now;
            w_prev <= cfg_window;
        end
    end

    // Change detect, enable and result gating.
    always_comb begin
        q_now   = queue_e'(cfg_queue);
        cfg_chg = (q_now != q_prev) | (cfg_window != w_prev);
        enabled = (q_now != Q_OFF);
        flush   = cfg_chg | ~enabled;
        step    = res_valid & ~flush;
    end

    thr_range_cmp #(.DATA_W(DATA_W)) u_cmp (
        .data        (res_data),
        .lo          (thr_lo),
        .hi          (thr_hi),
        .window      (cfg_window),
        .hit         (hit),
        .release_hit (release_hit)
    );

    thr_run_cnt u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .step    (step),
        .hit     (hit),
        .need    (run_needed(q_now)),
        .cnt     (run_cnt),
        .reached (reached)
    );

    thr_alert_state u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .set   (reached),
        .latch (cfg_latch),
        .rel   (step & release_hit),
        .ack   (conv_read | alert_resp),
        .on    (alert_on)
    );

    // Pin drive: polarity applied after masking with the enable.
    always_comb begin
        active      = alert_on & enabled;
        alert_level = cfg_active_high ? active : ~active;
        alert_oe    = enabled;
    end

endmodule

// File: rtl/thr_alert_chk.sv
// Property checker for thr_alert_cmp, attached by bind.
module thr_alert_chk
    import thr_alert_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic [DATA_W-1:0] thr_hi,
    input logic              cfg_window,
    input logic              cfg_latch,
    input logic [1:0]        cfg_queue,
    input logic              conv_read,
    input logic              alert_resp,
    input logic              cfg_chg,
    input logic              alert_on,
    input logic [CNT_W-1:0]  run_cnt
);

    assert_off_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_queue == 2'b11) |=> !alert_on);

    assert_single_run_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !cfg_chg && cfg_queue == 2'b00 && !cfg_window &&
         $signed(res_data) > $signed(thr_hi)) |=> alert_on);

    assert_miss_restarts_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !cfg_window && $signed(res_data) <= $signed(thr_hi))
        |=> (run_cnt == '0));

    assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_latch && alert_on && !conv_read && !alert_resp && !cfg_chg &&
         cfg_queue != 2'b11) |=> alert_on);

    assert_ack_ignored_unlatched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_latch && !res_valid && !cfg_chg && cfg_queue != 2'b11)
        |=> $stable(alert_on));

    assert_change_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (!alert_on && run_cnt == '0));

    assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !cfg_chg && cfg_queue != 2'b11 &&
         !(cfg_latch && (conv_read || alert_resp)))
        |=> ($stable(alert_on) && $stable(run_cnt)));

endmodule

bind thr_alert_cmp thr_alert_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .thr_hi     (thr_hi),
    .cfg_window (cfg_window),
    .cfg_latch  (cfg_latch),
    .cfg_queue  (cfg_queue),
    .conv_read  (conv_read),
    .alert_resp (alert_resp),
    .cfg_chg    (cfg_chg),
    .alert_on   (alert_on),
    .run_cnt    (run_cnt)
);

// File: tb/test_thr_alert_cmp.sv
module test_thr_alert_cmp;

    localparam int DW    = 12;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    int   b_data = 0, b_lo = -100, b_hi = 100, b_q = 3;
    logic b_valid = 0, b_w = 0, b_ah = 0, b_lt = 0, b_rd = 0, b_ar = 0;

    logic [DW-1:0] res_data, thr_lo, thr_hi;
    logic          alert_level, alert_oe;

    assign res_data = b_data[DW-1:0];
    assign thr_lo   = b_lo[DW-1:0];
    assign thr_hi   = b_hi[DW-1:0];

    int   n_tests = 0, n_fail = 0;
    bit   done = 0;
    int   m_cnt = 0, m_pq = 3;
    logic m_on = 0, m_pw = 0;

    always #(CLK_P/2) clk = ~clk;

    thr_alert_cmp #(.DATA_W(DW)) i_thr_alert_cmp (
        .clk(clk), .rst_n(rst_n), .res_valid(b_valid), .res_data(res_data),
        .thr_lo(thr_lo), .thr_hi(thr_hi), .cfg_window(b_w),
        .cfg_active_high(b_ah), .cfg_latch(b_lt), .cfg_queue(b_q[1:0]),
        .conv_read(b_rd), .alert_resp(b_ar),
        .alert_level(alert_level), .alert_oe(alert_oe));

    function automatic int need_of(input int q);
        return (q == 0) ? 1 : (q == 1) ? 2 : 4;
    endfunction

    // Bench model of one clock edge, from the requirements.
    task automatic model_step();
        bit chg, hit, rel, ack;
        int inc;
        chg  = (b_q != m_pq) || (b_w != m_pw);
        m_pq = b_q; m_pw = b_w;
        ack  = b_lt && (b_rd || b_ar);
        if (chg || b_q == 3) begin
            m_on = 0; m_cnt = 0;
        end else if (b_valid) begin
            hit = b_w ? (b_data > b_hi || b_data < b_lo) : (b_data > b_hi);
            rel = !b_lt && (b_w ? !hit : (b_data < b_lo));
            inc = hit ? ((m_cnt < 4) ? m_cnt + 1 : 4) : 0;
            m_cnt = inc;
            if (hit && inc >= need_of(b_q)) m_on = 1;
            else if (ack) m_on = 0;
            else if (rel) m_on = 0;
        end else if (ack) begin
            m_on = 0;
        end
    endtask

    task automatic check(input string tag);
        logic exp_oe, act, exp_lvl;
        exp_oe  = (b_q != 3);
        act     = m_on && exp_oe;
        exp_lvl = b_ah ? act : !act;
        n_tests++;
        if (alert_oe !== exp_oe || alert_level !== exp_lvl) begin
            n_fail++;
            $display("FAIL %s: oe=%b level=%b expected oe=%b level=%b",
                     tag, alert_oe, alert_level, exp_oe, exp_lvl);
        end
    endtask

    task automatic tick(input string tag);
        model_step();
        @(negedge clk);
        check(tag);
        b_valid = 0; b_rd = 0; b_ar = 0;
    endtask

    task automatic res(input int v, input string tag);
        b_valid = 1; b_data = v;
        tick(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd5171));
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1;
        tick("R1 after release");

        // One-sided style, run of one, hysteresis.
        b_q = 0; tick("R10 config change");
        res(150, "R3 single over hi");
        res(50, "R5 in band holds");
        b_valid = 0; b_data = 150; tick("R12 no valid no change");
        res(-150, "R5 below lo clears");
        res(-1 + 0, "R11 minus one not above hi");

        // Run of two with break.
        b_q = 1; tick("R10 queue change");
        res(150, "R3 first of two");
        res(0, "R4 miss restarts");
        res(150, "R4 run restarted");
        res(150, "R3 second of two fires");
        res(-150, "R5 clear");

        // Run of four.
        b_q = 2; tick("R10 queue change");
        res(150, "R3 run4 one");
        res(150, "R3 run4 two");
        res(150, "R3 run4 three");
        res(150, "R3 run4 fires");
        b_rd = 1; b_ar = 1; tick("R8 ack ignored when not latching");
        b_ah = 1; tick("R9 active high");
        b_ah = 0; tick("R9 active low");
        res(-150, "R5 clear");

        // Band style.
        b_q = 0; b_w = 1; tick("R10 mode change");
        res(-150, "R6 below lo fires");
        res(0, "R6 in band clears");
        res(150, "R6 above hi fires");

        // Latching.
        b_lt = 1;
        res(0, "R7 latched ignores in band");
        b_rd = 1; tick("R7 read clears");
        res(150, "R7 set");
        b_ar = 1; tick("R7 alert response clears");
        b_rd = 1; res(150, "R7 set wins over read");

        // Disable.
        b_ah = 1; b_q = 3; tick("R2 disabled tristate");
        res(150, "R2 result ignored");
        b_ah = 0; tick("R2 inactive level low polarity");
        b_q = 0; tick("R10 re-enable");
        res(150, "R7 set again");
        b_w = 0; res(150, "R10 change clears and discards");
        tick("R10 stays clear");

        // Signed extremes.
        b_lt = 0; b_lo = -2048; b_hi = 2047;
        res(2047, "R11 max not above max");
        res(-2048, "R11 min no alert");

        // Constrained random phase.
        b_lo = -100; b_hi = 100;
        for (int i = 0; i < 3000; i++) begin
            int k;
            k = $urandom % 10;
            b_valid = (k < 7);
            case ($urandom % 4)
                0: b_data = b_hi + int'($urandom % 7) - 3;
                1: b_data = b_lo + int'($urandom % 7) - 3;
                2: b_data = int'($urandom % 400) - 200;
                default: b_data = int'($urandom % 4096) - 2048;
            endcase
            if ($urandom % 40 == 0) b_q = int'($urandom % 4);
            if ($urandom % 60 == 0) b_w = ~b_w;
            if ($urandom % 30 == 0) b_ah = ~b_ah;
            if ($urandom % 50 == 0) b_lt = ~b_lt;
            b_rd = ($urandom % 12 == 0);
            b_ar = ($urandom % 20 == 0);
            if ($urandom % 200 == 0) begin
                b_lo = -int'($urandom % 1000);
                b_hi = int'($urandom % 1000);
            end
            tick("R3 random");
        end
        finish_run();
    end

endmodule